// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

A single timer channel that produces a pulse-width and frequency modulated output from its own up-counter. The counter steps once per prescaler enable pulse. It runs from 1 up to the active period value and then returns to 1, and each return to 1 starts a new PWM cycle. The output sits at its active level for counts 1 through the active duty value and at the opposite level for the rest of the cycle.

Software never writes the active period and duty registers directly. It writes staging copies through a small register port. Both active copies take the staged values together, in the system clock where the counter has just entered the value 1. A hold bit can postpone that transfer over any number of cycles, so that several channels can be switched at once. The staged duty register is written at any time; the active one changes only at the boundary.

The active copy of the duty value lags by one system clock inside the load window. For that clock only, a staged duty of 0 or 1 is compared in place of the old active value, so that the first count of the new cycle already shows the new duty. A sticky event flag marks each cycle start. When the flag-on-duty mode bit is set, the flag is also raised when the count first equals the duty value.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: While reset is asserted and right after it, `pwm_out` is 1 and `flag` is 0. All staging, active and control registers reset to 0, and the counter resets to 0, which counts as the inactive region.
- R2: The counter changes only in the clock after a sampled `presc_en` pulse. From 0, or from any value at or above the active period, it goes to 1; otherwise it goes up by one.
- R3: Register port: `wr_sel`=0 writes the staged duty and `wr_sel`=1 writes the staged period. `wr_sel`=2 writes the controls: bit0 is flag-on-duty mode, bit1 is output polarity, bit2 is update hold. Staged duty and period reach the active copies only at the boundary clock, which is the first system clock in which the counter holds 1. The active copies take the staged values on the edge that ends the boundary clock.
- R4: While the update-hold bit is 1 at the boundary clock, the active duty and period keep their values.
- R5: One clock after the counter shows value c, `pwm_out` equals the polarity bit if 1 <= c <= compare-duty, and its complement otherwise. A duty of 0 therefore gives a constant inactive level, and a duty at or above the period gives a constant active level.
- R6: The compare-duty is the active duty, except in the boundary clock with hold clear and staged duty equal to 0 or 1. In that clock it is the staged duty.
- R7: `flag` is set one clock after every boundary clock. When flag-on-duty mode is 1, it is also set one clock after the first clock of a count that equals a nonzero compare-duty.
- R8: `flag` stays set until `flag_clr` is sampled high. If a set event and `flag_clr` fall on the same clock, the set wins.
- R9: Writing the polarity bit inverts the output levels from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 staged duty, 1 staged period, 2 controls |
| wr_data | input | CNT_W | Write data |
| presc_en | input | 1 | Prescaled count enable, one pulse per count step |
| flag_clr | input | 1 | Clears the event flag |
| pwm_out | output | 1 | PWM output |
| flag | output | 1 | Sticky event flag |

## Verification
The bench runs the counter with widely spaced ticks and with a tick in every clock. Under back-to-back ticks the load window overlaps the next count. There, a staged duty of 0 must suppress the active level at count 1, and a staged duty of 1 must produce it. A design without the load-window substitution shows a one-clock pulse of the wrong level at each cycle start. The bench also changes staged values while the hold bit is set and checks that the old waveform continues until hold is cleared; a design that ignored hold would switch at once. A set and a clear of the flag land on the same clock, and the flag must remain set. Duty 0 must give a flat inactive output, and duty at or above the period a flat active output; an off-by-one compare shows up as a stray edge.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  typedef enum logic [1:0] {
    SEL_DUTY   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // bit2 hold, bit1 polarity, bit0 flag-on-duty
  typedef struct packed {
    logic hold;
    logic pol;
    logic flag_on_duty;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             fresh,
  output logic             boundary
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] per);
    return ((cur == '0) || (cur >= per)) ? ONE : cur + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= tick;
      if (tick) count <= next_count(count, period);
    end
  end

  // first system clock of a count that starts a cycle
  assign boundary = fresh && (count == ONE);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count != '0));

endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             boundary,
  output logic [CNT_W-1:0] duty_stage,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] period_act,
  output ctrl_t            ctrl
);

  logic [CNT_W-1:0] period_stage;
  logic             load_now;

  assign load_now = boundary && !ctrl.hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_stage   <= '0;
      period_stage <= '0;
      ctrl         <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_DUTY:   duty_stage   <= wr_data;
        SEL_PERIOD: period_stage <= wr_data;
        SEL_CTRL:   ctrl         <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_act   <= '0;
      period_act <= '0;
    end else if (load_now) begin
      duty_act   <= duty_stage;
      period_act <= period_stage;
    end
  end

  assert_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !ctrl.hold) |=> (duty_act == $past(duty_stage)) && (period_act == $past(period_stage)));

  assert_no_midcycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(duty_act) && $stable(period_act));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && ctrl.hold) |=> $stable(duty_act) && $stable(period_act));

endmodule

// File: rtl/pwm_match_out.sv
module pwm_match_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             fresh,
  input  logic             boundary,
  input  logic [CNT_W-1:0] duty_stage,
  input  logic [CNT_W-1:0] duty_act,
  input  logic             hold,
  input  logic             pol,
  input  logic             flag_on_duty,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic             flag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] pick_duty(input logic strobe, input logic hld,
                                                 input logic [CNT_W-1:0] stage,
                                                 input logic [CNT_W-1:0] act);
    return (strobe && !hld && (stage <= ONE)) ? stage : act;
  endfunction

  function automatic logic in_active(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] duty);
    return (cnt != '0) && (cnt <= duty);
  endfunction

  logic [CNT_W-1:0] duty_cmp;
  logic             active_now;
  logic             duty_hit;
  logic             flag_set;

  assign duty_cmp   = pick_duty(boundary, hold, duty_stage, duty_act);
  assign active_now = in_active(count, duty_cmp);
  assign duty_hit   = fresh && (count == duty_cmp) && (duty_cmp != '0);
  assign flag_set   = boundary || (flag_on_duty && duty_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_out <= 1'b1;
      flag    <= 1'b0;
    end else begin
      pwm_out <= active_now ? pol : ~pol;
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && (duty_act == '0)) |=> (pwm_out == ~$past(pol)));

  assert_bypass_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !hold && (duty_stage == '0)) |=> (pwm_out == ~$past(pol)));

  assert_bypass_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !hold && (duty_stage == ONE)) |=> (pwm_out == $past(pol)));

  assert_boundary_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> flag);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             presc_en,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic             flag
);

  initial begin
    if (CNT_W < CTRL_W) $error("CNT_W must hold the control bits");
  end

  logic [CNT_W-1:0] count;
  logic             fresh;
  logic             boundary;
  logic [CNT_W-1:0] duty_stage;
  logic [CNT_W-1:0] duty_act;
  logic [CNT_W-1:0] period_act;
  ctrl_t            ctrl;

  pwm_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (presc_en),
    .period   (period_act),
    .count    (count),
    .fresh    (fresh),
    .boundary (boundary)
  );

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .boundary   (boundary),
    .duty_stage (duty_stage),
    .duty_act   (duty_act),
    .period_act (period_act),
    .ctrl       (ctrl)
  );

  pwm_match_out #(.CNT_W(CNT_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .count        (count),
    .fresh        (fresh),
    .boundary     (boundary),
    .duty_stage   (duty_stage),
    .duty_act     (duty_act),
    .hold         (ctrl.hold),
    .pol          (ctrl.pol),
    .flag_on_duty (ctrl.flag_on_duty),
    .flag_clr     (flag_clr),
    .pwm_out      (pwm_out),
    .flag         (flag)
  );

  assert_reset_level_R1: assert property (@(posedge clk)
    !rst_n |=> (pwm_out && !flag));

endmodule

// File: tb/tb_pwm_dbuf_channel.sv
`timescale 1ns/1ps
module tb_pwm_dbuf_channel;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd3;
  logic [CNT_W-1:0] wr_data = '0;
  logic             presc_en = 1'b0;
  logic             flag_clr = 1'b0;
  logic             pwm_out;
  logic             flag;

  pwm_dbuf_channel #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .presc_en(presc_en), .flag_clr(flag_clr), .pwm_out(pwm_out), .flag(flag)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  int    q_due[$];
  bit    q_out[$];
  bit    q_flag[$];
  string q_tag[$];

  // requirement-level model
  int m_cnt = 0, m_a1 = 0, m_b1 = 0, m_a2 = 0, m_b2 = 0;
  bit m_mode = 0, m_pol = 0, m_hold = 0, m_flag = 0;
  bit m_load = 0, m_set = 0, m_out_next = 1;

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(pwm_out, q_out[0], q_tag[0], "pwm_out");
      chk(flag, q_flag[0], q_tag[0], "flag");
      void'(q_due.pop_front());
      void'(q_out.pop_front());
      void'(q_flag.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // one system clock of stimulus, with the expected outputs after that edge
  task automatic step(input bit tick, input bit clr, input bit we, input int sel,
                      input int data, input string tag);
    bit fresh, strobe;
    int dcmp;
    @(negedge clk);
    presc_en = tick;
    flag_clr = clr;
    wr_en    = we;
    wr_sel   = 2'(sel);
    wr_data  = CNT_W'(data);
    fresh = tick;
    if (tick) m_cnt = (m_cnt == 0 || m_cnt >= m_b1) ? 1 : m_cnt + 1;
    if (m_load) begin m_a1 = m_a2; m_b1 = m_b2; end
    if (m_set) m_flag = 1;
    else if (clr) m_flag = 0;
    if (we) begin
      case (sel)
        0: m_a2 = data;
        1: m_b2 = data;
        2: begin m_mode = data[0]; m_pol = data[1]; m_hold = data[2]; end
        default: ;
      endcase
    end
    q_due.push_back(cyc + 1);
    q_out.push_back(m_out_next);
    q_flag.push_back(m_flag);
    q_tag.push_back(tag);
    strobe = fresh && (m_cnt == 1);
    dcmp = (strobe && !m_hold && m_a2 <= 1) ? m_a2 : m_a1;
    m_out_next = (m_cnt >= 1 && m_cnt <= dcmp) ? m_pol : !m_pol;
    m_load = strobe && !m_hold;
    m_set  = strobe || (m_mode && fresh && m_cnt == dcmp && dcmp != 0);
  endtask

  task automatic wr(input int sel, input int data, input string tag);
    step(0, 0, 1, sel, data, tag);
  endtask

  task automatic tick4(input int clr_at, input string tag);
    for (int i = 0; i < 4; i++) step(i == 0, i == clr_at, 0, 3, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwm_out, 1'b1, "R1", "reset pwm_out");
    chk(flag, 1'b0, "R1", "reset flag");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 3, 0, "R1");

    // staged values are invisible until a boundary
    wr(0, 3, "R3");
    wr(1, 6, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 3, 0, "R3");
    for (int i = 0; i < 14; i++) tick4(-1, "R5");
    // counter holds without ticks
    for (int i = 0; i < 6; i++) step(0, 0, 0, 3, 0, "R2");

    // flag clear, then flag-on-duty mode; a clear on the set clock loses
    step(0, 1, 0, 3, 0, "R8");
    step(0, 0, 0, 3, 0, "R8");
    for (int i = 0; i < 6; i++) tick4(2, "R7");
    wr(2, 3'b001, "R7");
    for (int i = 0; i < 12; i++) tick4(2, "R7");
    for (int i = 0; i < 8; i++) tick4(1, "R8");

    // hold postpones the transfer
    wr(2, 3'b100, "R4");
    wr(0, 1, "R4");
    wr(1, 4, "R4");
    for (int i = 0; i < 14; i++) tick4(-1, "R4");
    wr(2, 3'b000, "R3");
    for (int i = 0; i < 10; i++) tick4(-1, "R3");

    // polarity
    wr(2, 3'b010, "R9");
    for (int i = 0; i < 10; i++) tick4(-1, "R9");
    wr(2, 3'b000, "R9");

    // duty extremes
    wr(0, 0, "R5");
    for (int i = 0; i < 10; i++) tick4(-1, "R5");
    wr(0, 9, "R5");
    for (int i = 0; i < 10; i++) tick4(-1, "R5");

    // back-to-back ticks: load window substitution
    wr(0, 5, "R6");
    wr(1, 6, "R6");
    for (int i = 0; i < 8; i++) tick4(-1, "R6");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 3, 0, "R6");
    step(1, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 14; i++) step(1, 0, 0, 3, 0, "R6");
    step(1, 0, 1, 0, 1, "R6");
    for (int i = 0; i < 14; i++) step(1, 0, 0, 3, 0, "R6");
    wr(2, 3'b010, "R6");
    step(1, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 14; i++) step(1, 0, 0, 3, 0, "R6");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 3, 0, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule